// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus that a target device has left hung, typically with SDA held low after a transfer was cut short. A controller issues a single-cycle recover strobe. The sequencer then looks at the synchronized line levels. If SDA is low, it clocks SCL through a bounded burst of pulses and ends the burst as soon as the target lets SDA go. It then drives a STOP condition and signals completion with a one-cycle done pulse. A fail flag, valid from that pulse onward, tells whether SDA was actually free at the end.

Every phase of the sequence lasts from one timing tick to the next, so the pulse rate on SCL is set by the tick generator outside the block. Alongside the sequencer, a line monitor reports the synchronized SCL and SDA levels. It also keeps a bus-busy flag that follows START and STOP conditions seen on the lines. Both lines are open-drain: each output is a pull-low enable, and a 1 means the line is driven low.

Top module: `i2c_bus_recover`

## Requirements
- R1: After a synchronous reset, both pull-low enables, done_o, fail_o and busy_o are 0, and both level outputs read 1.
- R2: A recover strobe that finds both synchronized lines high drives neither line, raises done_o on the next cycle and leaves fail_o at 0.
- R3: A recover strobe that finds synchronized SDA low starts SCL pulses. Each pulse holds SCL low from one tick to the next and then releases it from one tick to the next. The first low phase begins on the cycle after the strobe.
- R4: At the tick that ends each released-SCL phase, the pulse burst stops if synchronized SDA reads high. It also stops when that phase completes the eighth pulse (MAX_PULSES). No burst has fewer than one or more than eight pulses.
- R5: The STOP sequence has three phases, each lasting one tick interval. First SCL and SDA are both driven low. Then SCL is released while SDA stays low. Then SDA is released. The tick that ends the third phase finishes the operation.
- R6: done_o is high for exactly one cycle per accepted recover strobe.
- R7: fail_o is set to the inverse of synchronized SDA on the cycle done_o rises. It holds that value until the next accepted recover strobe clears it.
- R8: scl_lvl_o and sda_lvl_o follow scl_i and sda_i delayed by two clock cycles, through a two-flop synchronizer.
- R9: busy_o sets when synchronized SDA falls while synchronized SCL stays high (START). It clears when synchronized SDA rises while SCL stays high (STOP).
- R10: A recover strobe that arrives while a sequence is in progress has no effect on the lines, the pulse count or done_o.
- R11: A recover strobe that finds SDA high but SCL low skips the pulse burst and runs only the STOP sequence of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Phase-advance pulse from the timing generator |
| recover_i | input | 1 | Single-cycle recover command strobe |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| scl_oe_o | output | 1 | SCL pull-low enable (1 drives low) |
| sda_oe_o | output | 1 | SDA pull-low enable (1 drives low) |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | SDA still low at completion |
| scl_lvl_o | output | 1 | Synchronized SCL level |
| sda_lvl_o | output | 1 | Synchronized SDA level |
| busy_o | output | 1 | Bus busy between START and STOP |

## Verification
The sequencer and the line monitor both read the same synchronized SDA. A target grabbing SDA, which the monitor sees as a START, can therefore land in the exact cycle the recover strobe is sampled. The bench provokes this by asserting the stuck target's SDA hold and then timing the strobe so both events fall on the same edge, two synchronizer stages later. A behavioural model of the lines, the stuck target and both functions is compared against every output on every clock. That comparison shows the busy flag setting in the same cycle the pulse burst begins, with neither event disturbing the other.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;

  // Phases of a recovery operation
  typedef enum logic [2:0] {
    RS_IDLE    = 3'd0,  // waiting for a command
    RS_CLK_LO  = 3'd1,  // pulse: SCL held low
    RS_CLK_HI  = 3'd2,  // pulse: SCL released, SDA judged at the end
    RS_STP_LO  = 3'd3,  // stop: both lines low
    RS_STP_SCL = 3'd4,  // stop: SCL released, SDA still low
    RS_STP_SDA = 3'd5   // stop: SDA released
  } rcv_state_e;

endpackage

// File: rtl/i2c_rcv_sync.sv
// Multi-stage synchronizer for a vector of line inputs; resets to the idle-high level.
module i2c_rcv_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] shreg;
      always_ff @(posedge clk) begin
        if (rst) shreg <= '1;
        else     shreg <= {shreg[STAGES-2:0], d[g]};
      end
      assign q[g] = shreg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2c_rcv_linemon.sv
// Watches the synchronized lines for START and STOP and keeps a busy flag.
module i2c_rcv_linemon (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic busy
);

  logic scl_p, sda_p;
  logic start_det, stop_det;

  assign start_det = scl_s & scl_p &  sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p &  sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
      if (start_det)     busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_rcv_seq.sv
// Tick-paced recovery sequence: pulse burst, then STOP, then done.
module i2c_rcv_seq
  import i2c_rcv_pkg::*;
#(
  parameter int MAX_PULSES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic recover,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_oe,
  output logic sda_oe,
  output logic done,
  output logic fail
);

  localparam int CNT_W = $clog2(MAX_PULSES + 1);
  localparam logic [CNT_W-1:0] LAST_PULSE = CNT_W'(MAX_PULSES - 1);

  rcv_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fin;
  logic             accept;

  assign accept = (state_q == RS_IDLE) && recover;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fin     = 1'b0;
    case (state_q)
      RS_IDLE: begin
        if (recover) begin
          cnt_d = '0;
          if (!sda_s)      state_d = RS_CLK_LO;
          else if (!scl_s) state_d = RS_STP_LO;
          else             fin     = 1'b1;
        end
      end
      RS_CLK_LO: if (tick) state_d = RS_CLK_HI;
      RS_CLK_HI: begin
        if (tick) begin
          cnt_d = cnt_q + CNT_W'(1);
          if (sda_s || (cnt_q == LAST_PULSE)) state_d = RS_STP_LO;
          else                                state_d = RS_CLK_LO;
        end
      end
      RS_STP_LO:  if (tick) state_d = RS_STP_SCL;
      RS_STP_SCL: if (tick) state_d = RS_STP_SDA;
      RS_STP_SDA: begin
        if (tick) begin
          state_d = RS_IDLE;
          fin     = 1'b1;
        end
      end
      default: state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RS_IDLE;
      cnt_q   <= '0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
      done    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      scl_oe  <= (state_d == RS_CLK_LO) || (state_d == RS_STP_LO);
      sda_oe  <= (state_d == RS_STP_LO) || (state_d == RS_STP_SCL);
      done    <= fin;
      if (fin)         fail <= ~sda_s;
      else if (accept) fail <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover #(
  parameter int MAX_PULSES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic recover_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic done_o,
  output logic fail_o,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic busy_o
);

  localparam int N_LINES = 2;

  logic [N_LINES-1:0] lines_raw, lines_s;
  logic               scl_s, sda_s;

  assign lines_raw = {scl_i, sda_i};
  assign scl_s     = lines_s[1];
  assign sda_s     = lines_s[0];

  i2c_rcv_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_LINES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (lines_raw),
    .q   (lines_s)
  );

  i2c_rcv_linemon u_mon (
    .clk   (clk),
    .rst   (rst),
    .scl_s (scl_s),
    .sda_s (sda_s),
    .busy  (busy_o)
  );

  i2c_rcv_seq #(.MAX_PULSES(MAX_PULSES)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_i),
    .recover (recover_i),
    .scl_s   (scl_s),
    .sda_s   (sda_s),
    .scl_oe  (scl_oe_o),
    .sda_oe  (sda_oe_o),
    .done    (done_o),
    .fail    (fail_o)
  );

  assign scl_lvl_o = scl_s;
  assign sda_lvl_o = sda_s;

endmodule

// File: rtl/i2c_bus_recover_chk.sv
module i2c_bus_recover_chk #(
  parameter int MAX_PULSES = 8
) (
  input logic clk,
  input logic rst,
  input logic tick_i,
  input logic recover_i,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic done_o,
  input logic fail_o,
  input logic scl_lvl_o,
  input logic sda_lvl_o,
  input logic busy_o
);

  logic [15:0] rise_cnt;
  logic        scl_oe_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_cnt <= '0;
      scl_oe_p <= 1'b0;
    end else begin
      scl_oe_p <= scl_oe_o;
      if (done_o)                      rise_cnt <= '0;
      else if (scl_oe_o && !scl_oe_p)  rise_cnt <= rise_cnt + 16'd1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6

  AST_LINES_FREE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!scl_oe_o && !sda_oe_o)); // R5

  AST_SDA_DRIVE_UNDER_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> scl_oe_o); // R5

  AST_SCL_MOVES_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
    !$stable(scl_oe_o) |-> ($past(tick_i) || $past(recover_i))); // R3

  AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$stable(fail_o) |-> (done_o || $past(recover_i))); // R7

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> ($past(scl_lvl_o) && !$past(sda_lvl_o))); // R9

  AST_BUSY_OFF_STOP: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> ($past(scl_lvl_o) && $past(sda_lvl_o))); // R9

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
    rise_cnt <= 16'(MAX_PULSES + 1)); // R4

endmodule

bind i2c_bus_recover i2c_bus_recover_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_i    (tick_i),
  .recover_i (recover_i),
  .scl_oe_o  (scl_oe_o),
  .sda_oe_o  (sda_oe_o),
  .done_o    (done_o),
  .fail_o    (fail_o),
  .scl_lvl_o (scl_lvl_o),
  .sda_lvl_o (sda_lvl_o),
  .busy_o    (busy_o)
);

// File: tb/i2c_bus_recover_bench.sv
`timescale 1ns/1ps
module i2c_bus_recover_bench;

  localparam int MAXP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic recover = 1'b0;
  logic scl_ext_low = 1'b0;
  logic dev_low = 1'b0;
  int   dev_need = 0;
  int   dev_edges = 0;

  logic scl_oe, sda_oe, done, fail, scl_lvl, sda_lvl, busy;
  logic scl_line, sda_line;

  assign scl_line = !(scl_oe | scl_ext_low);
  assign sda_line = !(sda_oe | dev_low);

  always #2.5 clk = ~clk;

  i2c_bus_recover #(.MAX_PULSES(MAXP), .SYNC_STAGES(2)) u_i2c_bus_recover (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .recover_i (recover),
    .scl_i     (scl_line),
    .sda_i     (sda_line),
    .scl_oe_o  (scl_oe),
    .sda_oe_o  (sda_oe),
    .done_o    (done),
    .fail_o    (fail),
    .scl_lvl_o (scl_lvl),
    .sda_lvl_o (sda_lvl),
    .busy_o    (busy)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Stuck target: holds SDA low until it has seen dev_need rising SCL edges
  always @(posedge scl_line) begin
    if (dev_low) begin
      dev_edges++;
      if (dev_edges >= dev_need) dev_low = 1'b0;
    end
  end

  // Tick generator: one tick every fifth cycle
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt = (tcnt == 4) ? 0 : tcnt + 1;
    tick <= (tcnt == 4);
  end

  // Behavioural reference model, advanced on each clock edge
  int  m_phase, m_cnt;
  bit  m_scl1, m_scl2, m_sda1, m_sda2, m_sclp, m_sdap;
  bit  m_busy, m_done, m_fail, m_scl_oe, m_sda_oe;
  bit  model_ok = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_cnt = 0;
      m_scl1 = 1; m_scl2 = 1; m_sda1 = 1; m_sda2 = 1; m_sclp = 1; m_sdap = 1;
      m_busy = 0; m_done = 0; m_fail = 0; m_scl_oe = 0; m_sda_oe = 0;
      model_ok = 1;
    end else begin
      bit o_scl, o_sda, fin;
      o_scl = m_scl2;
      o_sda = m_sda2;
      if (o_scl && m_sclp && m_sdap && !o_sda)      m_busy = 1;
      else if (o_scl && m_sclp && !m_sdap && o_sda) m_busy = 0;
      m_sclp = o_scl;
      m_sdap = o_sda;
      fin = 0;
      case (m_phase)
        0: if (recover) begin
             m_cnt = 0; m_fail = 0;
             if (!o_sda)      m_phase = 1;
             else if (!o_scl) m_phase = 3;
             else             fin = 1;
           end
        1: if (tick) m_phase = 2;
        2: if (tick) begin
             m_cnt++;
             m_phase = (o_sda || m_cnt == MAXP) ? 3 : 1;
           end
        3: if (tick) m_phase = 4;
        4: if (tick) m_phase = 5;
        5: if (tick) begin m_phase = 0; fin = 1; end
        default: m_phase = 0;
      endcase
      m_done = fin;
      if (fin) m_fail = !o_sda;
      m_scl_oe = (m_phase == 1) || (m_phase == 3);
      m_sda_oe = (m_phase == 3) || (m_phase == 4);
      m_scl2 = m_scl1; m_scl1 = scl_line;
      m_sda2 = m_sda1; m_sda1 = sda_line;
    end
  end

  // Every-cycle comparison and event counters, away from the active edge
  int  rises = 0;
  int  dones = 0;
  bit  prev_oe = 0;
  always @(negedge clk) begin
    if (!rst && model_ok) begin
      chk(scl_oe == m_scl_oe, "R3", "scl_oe per-cycle", scl_oe, m_scl_oe);
      chk(sda_oe == m_sda_oe, "R5", "sda_oe per-cycle", sda_oe, m_sda_oe);
      chk(done == m_done, "R6", "done per-cycle", done, m_done);
      chk(fail == m_fail, "R7", "fail per-cycle", fail, m_fail);
      chk(scl_lvl == m_scl2 && sda_lvl == m_sda2, "R8", "levels per-cycle",
          {scl_lvl, sda_lvl}, {m_scl2, m_sda2});
      chk(busy == m_busy, "R9", "busy per-cycle", busy, m_busy);
      if (scl_oe && !prev_oe) rises++;
      if (done) dones++;
      prev_oe = scl_oe;
    end
  end

  task automatic strobe();
    @(negedge clk); recover <= 1'b1;
    @(negedge clk); recover <= 1'b0;
  endtask

  task automatic wait_done();
    while (dones == 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic clear_counts();
    rises = 0; dones = 0;
  endtask

  task automatic stuck_run(input int need, input int exp_rises, input int exp_fail, input string req);
    @(negedge clk);
    dev_edges = 0; dev_need = need; dev_low = 1'b1;
    repeat (6) @(negedge clk);
    chk(busy == 1'b1, "R9", "busy after target grabs SDA", busy, 1);
    clear_counts();
    strobe();
    wait_done();
    chk(rises == exp_rises, req, "SCL low phases in run", rises, exp_rises);
    chk(dones == 1, "R6", "done pulses in run", dones, 1);
    chk(fail == exp_fail, "R7", "fail after run", fail, exp_fail);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(scl_oe == 0 && sda_oe == 0, "R1", "pull-low enables after reset", {scl_oe, sda_oe}, 0);
    chk(done == 0 && fail == 0 && busy == 0, "R1", "done/fail/busy after reset", {done, fail, busy}, 0);
    chk(scl_lvl == 1 && sda_lvl == 1, "R1", "levels after reset", {scl_lvl, sda_lvl}, 3);
    repeat (4) @(negedge clk);

    // R2: idle bus needs nothing
    clear_counts();
    strobe();
    wait_done();
    chk(rises == 0, "R2", "no drive on idle bus", rises, 0);
    chk(dones == 1, "R2", "done on idle bus", dones, 1);
    chk(fail == 0, "R2", "fail on idle bus", fail, 0);

    // R4: early stop after three pulses, then STOP clears busy
    stuck_run(3, 4, 0, "R4");
    chk(busy == 0, "R9", "busy cleared by generated STOP", busy, 0);
    // R3: exactly eight pulses needed
    stuck_run(8, 9, 0, "R3");
    // R4: single pulse
    stuck_run(1, 2, 0, "R4");
    // R7: target never lets go
    stuck_run(1000, 9, 1, "R7");
    @(negedge clk); dev_low = 1'b0;
    repeat (20) @(negedge clk);
    chk(fail == 1, "R7", "fail held until next command", fail, 1);

    // R11: SCL held low elsewhere, SDA high -> STOP only
    @(negedge clk); scl_ext_low = 1'b1;
    repeat (6) @(negedge clk);
    clear_counts();
    strobe();
    chk(fail == 0, "R7", "fail cleared by accepted command", fail, 0);
    wait_done();
    chk(rises == 1, "R11", "only the STOP low phase", rises, 1);
    chk(fail == 0, "R11", "fail with SDA free", fail, 0);
    @(negedge clk); scl_ext_low = 1'b0;
    repeat (10) @(negedge clk);

    // R10: second strobe during a run is ignored
    @(negedge clk);
    dev_edges = 0; dev_need = 5; dev_low = 1'b1;
    repeat (6) @(negedge clk);
    clear_counts();
    strobe();
    repeat (12) @(negedge clk);
    strobe();
    wait_done();
    chk(rises == 6, "R10", "pulse count with extra strobe", rises, 6);
    chk(dones == 1, "R10", "single done with extra strobe", dones, 1);

    // Same-cycle case: START detection and command sampled on one edge (R9, R3)
    @(negedge clk);
    dev_edges = 0; dev_need = 2; dev_low = 1'b1;
    @(negedge clk);
    clear_counts();
    @(negedge clk); recover <= 1'b1;
    @(negedge clk); recover <= 1'b0;
    wait_done();
    chk(rises == 3, "R3", "burst started with START in same cycle", rises, 3);
    chk(busy == 0, "R9", "busy after same-cycle run", busy, 0);

    repeat (10) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule